// File: doc/BRIEF.md
# Centronics host handshake engine

This block moves bytes from a host to a printer-style peripheral using the classic forward parallel-port handshake. On the host side a byte is offered with a valid/ready pair. On the peripheral side the block drives eight data lines and an active-low strobe. It samples a Busy input and an active-low acknowledge input. After a byte is accepted, the block puts it on the data lines and waits a programmable setup time. It then waits until the peripheral reports that it is not busy and drives a low strobe pulse of fixed length. The peripheral takes the byte on the rising edge of that strobe.

Busy and acknowledge are asynchronous to the block clock, so each passes through a two-flop synchronizer. The `ACK_WAIT` parameter selects what happens after the strobe. With `ACK_WAIT` = 0 the acknowledge is ignored, and the next byte may start at once; its strobe is held back only by Busy. With `ACK_WAIT` = 1 the block waits for a complete acknowledge pulse, low and then high, before it takes the next byte. A separate watch counter raises a sticky flag when Busy stays high for too long. A clear input resets that flag.

Top module: `strobe_xfer_host`

## Requirements
- R1: After reset, `pd_strobe_n` is 1, `in_ready` is 1, `to_flag` is 0 and `pd_data` is 0.
- R2: A byte is accepted in a cycle with `in_valid` and `in_ready` both high. From the next cycle `pd_data` carries that byte, and `in_ready` stays 0 until the transfer completes. `in_ready` is never 1 while `pd_strobe_n` is 0.
- R3: At least `SETUP_CYC` clock cycles pass between `pd_data` taking a new byte and the falling edge of `pd_strobe_n`.
- R4: `pd_strobe_n` stays low for exactly `STROBE_CYC` cycles. `pd_data` does not change while it is low. The value on `pd_data` at its rising edge is the accepted byte.
- R5: `pd_strobe_n` never falls while the synchronized Busy is 1. A byte accepted while Busy is high is held, not dropped. It is strobed out after Busy returns to 0.
- R6: With `ACK_WAIT` = 0, `in_ready` returns to 1 after the strobe rises, whatever `pd_ack_n` does.
- R7: With `ACK_WAIT` = 1, `in_ready` stays 0 after the strobe until the synchronized `pd_ack_n` has been seen at 0 and then at 1.
- R8: `to_flag` is set once the synchronized Busy has been 1 for `TIMEOUT_CYC` consecutive cycles, and not before. It then stays 1 after Busy falls.
- R9: `to_clear` forces `to_flag` to 0 in the following cycle. Clear wins over a set in the same cycle. The flag does not set again until a new high Busy period reaches the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | DATA_W | Byte offered by the host |
| pd_data | output | DATA_W | Data lines to the peripheral |
| pd_strobe_n | output | 1 | Active-low strobe to the peripheral |
| pd_busy | input | 1 | Peripheral busy, active high, asynchronous |
| pd_ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| to_clear | input | 1 | Clears the busy timeout flag |
| to_flag | output | 1 | Sticky busy timeout flag |

## Verification
The hardest case to reach from the ports is a byte that has already been accepted and then stalls because Busy is high. The bench raises Busy a few cycles before it offers the byte, so the synchronized Busy is already high when the setup time runs out. It keeps Busy high for less than the timeout limit and checks that no strobe appears and that ready stays low. It then drops Busy and expects the held byte to be strobed out. The acknowledge option uses a second instance that shares the same peripheral inputs. That instance must stay stalled after its strobe until the bench pulses the acknowledge line.

// File: rtl/sxh_pkg.sv
package sxh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_ACKLO,
      ST_ACKHI
   } sxh_state_t;

   function automatic int sxh_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sxh_sync.sv
module sxh_sync #(
   parameter int           W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("sxh_sync: W must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         logic meta;
         logic stab;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta <= RST_VAL[i];
               stab <= RST_VAL[i];
            end else begin
               meta <= d[i];
               stab <= meta;
            end
         end
         assign q[i] = stab;
      end
   endgenerate

endmodule

// File: rtl/sxh_busy_watch.sv
module sxh_busy_watch #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_s,
   input  logic clear,
   output logic flag
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sxh_busy_watch: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_cnt <= '0;
      else if (!busy_s)               run_cnt <= '0;
      else if (run_cnt != CW'(LIMIT)) run_cnt <= run_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    flag <= 1'b0;
      else if (clear)                                flag <= 1'b0;
      else if (busy_s && run_cnt == CW'(LIMIT - 1))  flag <= 1'b1;
   end

   // R9
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !flag);

   // R8
   flag_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(busy_s));

endmodule

// File: rtl/sxh_seq.sv
module sxh_seq
   import sxh_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 50,
   parameter int ACK_WAIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              busy_s,
   input  logic              ack_s,
   output logic              in_ready,
   output logic [DATA_W-1:0] pd_data,
   output logic              pd_strobe_n
);

   localparam int CW = $clog2(sxh_max(SETUP_CYC, STROBE_CYC) + 1);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("sxh_seq: SETUP_CYC must be at least 1");
      end
      if (STROBE_CYC < 1) begin : g_bad_strobe
         $error("sxh_seq: STROBE_CYC must be at least 1");
      end
      if (ACK_WAIT != 0 && ACK_WAIT != 1) begin : g_bad_ack
         $error("sxh_seq: ACK_WAIT must be 0 or 1");
      end
   endgenerate

   localparam sxh_state_t POST_STROBE = (ACK_WAIT != 0) ? ST_ACKLO : ST_IDLE;

   sxh_state_t        state;
   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] dreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         dreg  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  dreg  <= in_data;
                  cnt   <= CW'(SETUP_CYC - 1);
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (!busy_s) begin
                  cnt   <= CW'(STROBE_CYC - 1);
                  state <= ST_STROBE;
               end
            end
            ST_STROBE: begin
               if (cnt != '0) cnt   <= cnt - 1'b1;
               else           state <= POST_STROBE;
            end
            ST_ACKLO: begin
               if (!ack_s) state <= ST_ACKHI;
            end
            ST_ACKHI: begin
               if (ack_s) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready    = (state == ST_IDLE);
   assign pd_strobe_n = (state != ST_STROBE);
   assign pd_data     = dreg;

   // R4
   data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_strobe_n && $past(!pd_strobe_n)) |-> $stable(pd_data));

   // R5
   strobe_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_strobe_n) |-> !$past(busy_s));

   // R2
   no_ready_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_strobe_n |-> !in_ready);

endmodule

// File: rtl/strobe_xfer_host.sv
module strobe_xfer_host #(
   parameter int DATA_W      = 8,
   parameter int SETUP_CYC   = 2,
   parameter int STROBE_CYC  = 50,
   parameter int TIMEOUT_CYC = 5000,
   parameter int ACK_WAIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] pd_data,
   output logic              pd_strobe_n,
   input  logic              pd_busy,
   input  logic              pd_ack_n,
   input  logic              to_clear,
   output logic              to_flag
);

   logic [1:0] sync_q;
   logic       busy_s;
   logic       ack_s;

   sxh_sync #(.W(2), .RST_VAL(2'b10)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pd_ack_n, pd_busy}),
      .q     (sync_q)
   );

   assign busy_s = sync_q[0];
   assign ack_s  = sync_q[1];

   sxh_busy_watch #(.LIMIT(TIMEOUT_CYC)) i_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_s (busy_s),
      .clear  (to_clear),
      .flag   (to_flag)
   );

   sxh_seq #(
      .DATA_W     (DATA_W),
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .ACK_WAIT   (ACK_WAIT)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .busy_s      (busy_s),
      .ack_s       (ack_s),
      .in_ready    (in_ready),
      .pd_data     (pd_data),
      .pd_strobe_n (pd_strobe_n)
   );

endmodule

// File: tb/test_strobe_xfer_host.sv
module test_strobe_xfer_host;

   localparam int SU = 3;
   localparam int SW = 6;
   localparam int TO = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       v1 = 1'b0, v2 = 1'b0;
   logic [7:0] din = 8'h00;
   logic       busy = 1'b0, ack_n = 1'b1, clr = 1'b0;
   logic       r1, r2, sn1, sn2, f1, f2;
   logic [7:0] d1, d2;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   strobe_xfer_host #(.SETUP_CYC(SU), .STROBE_CYC(SW), .TIMEOUT_CYC(TO), .ACK_WAIT(0))
   i_strobe_xfer_host (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(r1), .in_data(din),
      .pd_data(d1), .pd_strobe_n(sn1), .pd_busy(busy), .pd_ack_n(ack_n),
      .to_clear(clr), .to_flag(f1));

   strobe_xfer_host #(.SETUP_CYC(SU), .STROBE_CYC(SW), .TIMEOUT_CYC(TO), .ACK_WAIT(1))
   i_strobe_xfer_host_ack (
      .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_ready(r2), .in_data(din),
      .pd_data(d2), .pd_strobe_n(sn2), .pd_busy(busy), .pd_ack_n(ack_n),
      .to_clear(clr), .to_flag(f2));

   // strobe monitor on the main instance
   logic       prev_sn = 1'b1;
   logic [7:0] prev_d = 8'h00;
   logic [7:0] low_d = 8'h00;
   int since = 0, lowcnt = 0, last_w = 0, last_su = 0, nstb = 0, unstable = 0;
   logic [7:0] last_b = 8'h00;
   logic prev_sn2 = 1'b1;
   int nstb2 = 0;

   always @(negedge clk) begin
      if (d1 != prev_d) since = 0; else since = since + 1;
      if (!sn1 && prev_sn) begin
         last_su = since;
         lowcnt  = 0;
         low_d   = d1;
      end
      if (!sn1) begin
         lowcnt = lowcnt + 1;
         if (d1 != low_d) unstable = unstable + 1;
      end
      if (sn1 && !prev_sn) begin
         last_w = lowcnt;
         last_b = d1;
         nstb   = nstb + 1;
      end
      if (sn2 && !prev_sn2) nstb2 = nstb2 + 1;
      prev_sn  = sn1;
      prev_sn2 = sn2;
      prev_d   = d1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send1(input logic [7:0] b);
      do @(negedge clk); while (!r1);
      din = b; v1 = 1'b1;
      @(negedge clk);
      v1 = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 strobe_n", sn1, 1);
      chk("R1 ready", r1, 1);
      chk("R1 flag", f1, 0);
      chk("R1 data", d1, 0);
   endtask

   task automatic t_single;
      int n0;
      n0 = nstb;
      send1(8'hA5);
      chk("R2 ready low after accept", r1, 0);
      chk("R2 data driven", d1, 8'hA5);
      wait_cyc(20);
      chk("R4 strobe count", nstb - n0, 1);
      chk("R4 strobe width", last_w, SW);
      chk("R4 captured byte", last_b, 8'hA5);
      chk("R3 setup >= SETUP_CYC", (last_su >= SU) ? 1 : 0, 1);
      chk("R6 ready back without ack", r1, 1);
   endtask

   task automatic t_stream;
      logic [7:0] pat [4];
      pat[0] = 8'h3C; pat[1] = 8'hFF; pat[2] = 8'h00; pat[3] = 8'h96;
      for (int k = 0; k < 4; k++) begin
         int n0;
         n0 = nstb;
         send1(pat[k]);
         wait_cyc(SU + SW + 4);
         chk("R4 stream byte", last_b, pat[k]);
         chk("R4 stream count", nstb - n0, 1);
         chk("R4 stream width", last_w, SW);
      end
      chk("R4 data stable during strobe", unstable, 0);
   endtask

   task automatic t_busy_hold;
      int n0;
      n0 = nstb;
      busy = 1'b1;
      wait_cyc(3);
      send1(8'h5A);
      wait_cyc(25);
      chk("R5 no strobe while busy", nstb - n0, 0);
      chk("R5 strobe_n high while busy", sn1, 1);
      chk("R5 byte held on lines", d1, 8'h5A);
      chk("R5 ready low while held", r1, 0);
      chk("R8 no flag before limit", f1, 0);
      busy = 1'b0;
      wait_cyc(SW + 6);
      chk("R5 held byte strobed", nstb - n0, 1);
      chk("R5 held byte value", last_b, 8'h5A);
   endtask

   task automatic t_timeout;
      busy = 1'b1;
      wait_cyc(TO - 6);
      chk("R8 flag not early", f1, 0);
      wait_cyc(12);
      chk("R8 flag set", f1, 1);
      busy = 1'b0;
      wait_cyc(6);
      chk("R8 flag sticky", f1, 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk("R9 flag cleared", f1, 0);
      // clear while busy stays high past the limit: no re-set in same episode
      busy = 1'b1;
      wait_cyc(TO + 8);
      chk("R8 flag set again", f1, 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      wait_cyc(5);
      chk("R9 clear holds while busy stays high", f1, 0);
      busy = 1'b0;
      wait_cyc(4);
   endtask

   task automatic t_ack;
      int n0;
      n0 = nstb2;
      do @(negedge clk); while (!r2);
      din = 8'h81; v2 = 1'b1;
      @(negedge clk);
      v2 = 1'b0;
      wait_cyc(SU + SW + 15);
      chk("R7 strobe done", nstb2 - n0, 1);
      chk("R7 waiting for ack", r2, 0);
      chk("R7 byte on lines", d2, 8'h81);
      ack_n = 1'b0;
      wait_cyc(10);
      chk("R7 still waiting during ack low", r2, 0);
      chk("R6 main instance ignores ack", r1, 1);
      ack_n = 1'b1;
      wait_cyc(6);
      chk("R7 ready after ack pulse", r2, 1);
   endtask

   initial begin
      fork
         begin
            wait_cyc(3);
            @(negedge clk);
            t_reset;
            rst_n = 1'b1;
            wait_cyc(3);
            t_single;
            t_stream;
            t_busy_hold;
            t_timeout;
            t_ack;
         end
         begin
            wait_cyc(20000);
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule